// File: doc/BRIEF.md
# Two-Class Router Output Scheduler

This block is the switch controller of an input-queued wormhole router that carries two traffic classes. Each input port holds two head-of-queue flits, one in a guaranteed-throughput (GT) queue and one in a best-effort (BE) queue, and presents their requested output port. GT traffic is planned offline so that it never collides. Once per flit cycle the block grants every GT head its output, with no arbitration and no flow-control check. It then gives the outputs that are still free to BE heads through one round-robin arbiter per output.

A BE packet that has won an output keeps that output until its end-of-packet flit has passed, so BE packets never interleave with each other. GT flits may still cut in between its flits. Each output holds a free-space counter for the BE buffer of the downstream neighbour, and a BE flit is sent only while that counter is non-zero. The downstream neighbour returns a credit pulse each time it drains one of its BE flits. Whenever the block pops a BE flit from one of its own input queues, it returns a credit pulse to the upstream neighbour of that input.

The results are registered. The crossbar selects, the class flags, the queue pop strobes and the credit returns computed from the requests of cycle k are held for the whole of cycle k+1. The queue logic in front of the block presents the next head flit on each input. The queues and the header parsing sit outside this block. A port index is an unsigned binary number of PW = ceil(log2(NPORT)) bits, and field p of a packed vector occupies bits [p*PW +: PW].

Top module: `flit_sched`

## Requirements
- R1: A GT request on input i with destination d produces, one clock later, sel_valid[d]=1, sel_gt[d]=1, sel_src field d equal to i and gt_pop[i]=1. This happens regardless of BE state or credits.
- R2: A BE flit is granted only on an output that no GT flit claims in the same cycle.
- R3: An input whose GT request is active in a cycle receives no BE grant in that cycle. gt_pop[i] and be_pop[i] are never both 1.
- R4: Among BE inputs contending for an unlocked output, the winner is the first requester found when searching upward with wrap-around, starting at the output's pointer. The pointer is 0 after reset and moves to one past the winner whenever a new packet is granted.
- R5: After a BE flit with be_eop=0 is granted on an output, that output grants BE flits only from the same input, until a flit of that input with be_eop=1 has been granted. Other BE inputs get no grant there, even if the owner has no request.
- R6: A GT flit that takes an output locked by an unfinished BE packet is sent in that cycle, and the lock stays with the same BE input.
- R7: Each output's free-space counter resets to BUF_DEPTH, decrements on each BE grant to that output and increments on each cr_in pulse for that output. No BE flit is granted to that output while the counter is zero.
- R8: GT grants do not consume credits and are granted on an output whose counter is zero.
- R9: cr_out[i] pulses for exactly the cycles in which be_pop[i] is 1, and does not pulse for GT pops.
- R10: After reset, all select, pop and credit outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one flit cycle per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| gt_req | input | NPORT | GT head flit present, per input |
| gt_dst | input | NPORT*PW | GT requested output, per input |
| be_req | input | NPORT | BE head flit present, per input |
| be_dst | input | NPORT*PW | BE requested output, per input |
| be_eop | input | NPORT | BE head flit ends its packet, per input |
| cr_in | input | NPORT | Credit returned by the downstream neighbour, per output |
| sel_valid | output | NPORT | Output carries a flit in this flit cycle |
| sel_gt | output | NPORT | The flit on this output is GT |
| sel_src | output | NPORT*PW | Crossbar select: source input, per output |
| gt_pop | output | NPORT | Read strobe for the GT queue, per input |
| be_pop | output | NPORT | Read strobe for the BE queue, per input |
| cr_out | output | NPORT | Credit returned to the upstream neighbour, per input |

## Verification
The bench targets the points where a GT flit and BE state meet. These cases are a GT flit taking an output in the middle of a locked BE packet, and a GT and a BE request on the same input. A design that let the GT flit release the lock would interleave two BE packets. A design that served both classes of one input would pop two flits through a single crossbar input. The bench follows the round-robin pointer over repeated contention and checks that it moves only on new packets. It also checks that a locked output stays idle when its owner pauses, where a faulty design would hand the output to another requester. The bench then drains an output's credits to zero, confirms that GT still passes, and confirms that a returned credit takes effect one cycle after it arrives. An off-by-one counter shows up there as a 25th grant or a missing grant.

// File: rtl/sched_pkg.sv
package sched_pkg;
   // next index with wrap-around over n ports
   function automatic int wrap_next(input int v, input int n);
      return (v >= n - 1) ? 0 : v + 1;
   endfunction
endpackage

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
   parameter int N  = 6,
   parameter int PW = 3
) (
   input  logic [N-1:0]  req,
   input  logic [PW-1:0] ptr,
   output logic          hit,
   output logic [PW-1:0] idx
);
   int c;
   always_comb begin
      hit = 1'b0;
      idx = '0;
      c   = 0;
      for (int k = 0; k < N; k++) begin
         c = (int'(ptr) + k) % N;
         if (!hit && req[c]) begin
            hit = 1'b1;
            idx = PW'(c);
         end
      end
   end
endmodule

// File: rtl/sched_credit.sv
module sched_credit #(
   parameter int DEPTH = 24,
   parameter int CW    = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic give,
   output logic ok
);
   logic [CW-1:0] cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= CW'(DEPTH);
      else        cnt <= cnt - CW'(take) + CW'(give);
   end
   assign ok = (cnt != '0);
endmodule

// File: rtl/flit_sched.sv
module flit_sched #(
   parameter int NPORT     = 6,
   parameter int BUF_DEPTH = 24,
   localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1,
   localparam int CW = $clog2(BUF_DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NPORT-1:0]    gt_req,
   input  logic [NPORT*PW-1:0] gt_dst,
   input  logic [NPORT-1:0]    be_req,
   input  logic [NPORT*PW-1:0] be_dst,
   input  logic [NPORT-1:0]    be_eop,
   input  logic [NPORT-1:0]    cr_in,
   output logic [NPORT-1:0]    sel_valid,
   output logic [NPORT-1:0]    sel_gt,
   output logic [NPORT*PW-1:0] sel_src,
   output logic [NPORT-1:0]    gt_pop,
   output logic [NPORT-1:0]    be_pop,
   output logic [NPORT-1:0]    cr_out
);
   import sched_pkg::*;

   if (NPORT < 2) begin : g_chk_n
      $error("flit_sched: NPORT must be at least 2");
   end
   if (BUF_DEPTH < 1) begin : g_chk_d
      $error("flit_sched: BUF_DEPTH must be at least 1");
   end

   // GT claim per output (lowest index if a schedule ever conflicts)
   logic [NPORT-1:0]         gt_hit;
   logic [NPORT-1:0][PW-1:0] gt_src;
   logic [NPORT-1:0]         gt_win;
   always_comb begin
      gt_hit = '0;
      gt_src = '0;
      gt_win = '0;
      for (int o = 0; o < NPORT; o++) begin
         for (int i = 0; i < NPORT; i++) begin
            if (!gt_hit[o] && gt_req[i] && gt_dst[i*PW +: PW] == PW'(o)) begin
               gt_hit[o] = 1'b1;
               gt_src[o] = PW'(i);
               gt_win[i] = 1'b1;
            end
         end
      end
   end

   // an input carries one flit per cycle: GT first
   logic [NPORT-1:0] be_elig;
   assign be_elig = be_req & ~gt_req;

   logic [NPORT-1:0]         cred_ok;
   logic [NPORT-1:0]         win_v;
   logic [NPORT-1:0][PW-1:0] win_i;

   for (genvar o = 0; o < NPORT; o++) begin : g_out
      logic [NPORT-1:0] cand;
      logic             rr_hit;
      logic [PW-1:0]    rr_idx;
      logic             lock_v;
      logic [PW-1:0]    lock_s;
      logic [PW-1:0]    ptr;

      for (genvar i = 0; i < NPORT; i++) begin : g_cand
         assign cand[i] = be_elig[i] && (be_dst[i*PW +: PW] == PW'(o))
                          && cred_ok[o] && !gt_hit[o];
      end

      sched_rr_pick #(.N(NPORT), .PW(PW)) u_rr (
         .req(cand), .ptr(ptr), .hit(rr_hit), .idx(rr_idx)
      );

      assign win_v[o] = lock_v ? cand[lock_s] : rr_hit;
      assign win_i[o] = lock_v ? lock_s : rr_idx;

      sched_credit #(.DEPTH(BUF_DEPTH), .CW(CW)) u_cred (
         .clk(clk), .rst_n(rst_n), .take(win_v[o]), .give(cr_in[o]),
         .ok(cred_ok[o])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lock_v <= 1'b0;
            lock_s <= '0;
            ptr    <= '0;
         end else if (win_v[o]) begin
            lock_v <= !be_eop[win_i[o]];
            lock_s <= win_i[o];
            if (!lock_v) ptr <= PW'(wrap_next(int'(win_i[o]), NPORT));
         end
      end
   end

   logic [NPORT-1:0] be_pop_n;
   always_comb begin
      be_pop_n = '0;
      for (int o = 0; o < NPORT; o++)
         if (win_v[o]) be_pop_n[win_i[o]] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_valid <= '0;
         sel_gt    <= '0;
         sel_src   <= '0;
         gt_pop    <= '0;
         be_pop    <= '0;
         cr_out    <= '0;
      end else begin
         for (int o = 0; o < NPORT; o++) begin
            sel_valid[o]         <= gt_hit[o] | win_v[o];
            sel_gt[o]            <= gt_hit[o];
            sel_src[o*PW +: PW]  <= gt_hit[o] ? gt_src[o] : (win_v[o] ? win_i[o] : '0);
         end
         gt_pop <= gt_win;
         be_pop <= be_pop_n;
         cr_out <= be_pop_n;
      end
   end
endmodule

// File: rtl/flit_sched_chk.sv
module flit_sched_chk #(
   parameter int NPORT     = 6,
   parameter int BUF_DEPTH = 24,
   parameter int PW        = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NPORT-1:0]    gt_req,
   input logic [NPORT-1:0]    be_eop,
   input logic [NPORT-1:0]    cr_in,
   input logic [NPORT-1:0]    sel_valid,
   input logic [NPORT-1:0]    sel_gt,
   input logic [NPORT*PW-1:0] sel_src,
   input logic [NPORT-1:0]    gt_pop,
   input logic [NPORT-1:0]    be_pop
);
   localparam int UW = $clog2(BUF_DEPTH + 2) + 1;
   logic [NPORT-1:0] eop_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eop_q <= '0;
      else        eop_q <= be_eop;
   end

   // R8: every GT pop shows up as exactly one GT output
   a_r8_gt_count: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gt_pop) == $countones(sel_valid & sel_gt));

   for (genvar i = 0; i < NPORT; i++) begin : g_in
      a_r1_gt_granted: assert property (@(posedge clk) disable iff (!rst_n)
         gt_req[i] |=> gt_pop[i]);
      a_r3_one_flit_per_input: assert property (@(posedge clk) disable iff (!rst_n)
         !(gt_pop[i] && be_pop[i]));
   end

   for (genvar o = 0; o < NPORT; o++) begin : g_o
      logic          open;
      logic [PW-1:0] osrc;
      logic [UW-1:0] used;
      wire           be_here = sel_valid[o] && !sel_gt[o];
      wire [PW-1:0]  src     = sel_src[o*PW +: PW];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open <= 1'b0;
            osrc <= '0;
            used <= '0;
         end else begin
            if (be_here) begin
               open <= !eop_q[src];
               osrc <= src;
            end
            used <= used + UW'(be_here) - UW'(cr_in[o]);
         end
      end
      a_r5_no_interleave: assert property (@(posedge clk) disable iff (!rst_n)
         (be_here && open) |-> (src == osrc));
      a_r7_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
         used <= UW'(BUF_DEPTH));
   end
endmodule

bind flit_sched flit_sched_chk #(.NPORT(NPORT), .BUF_DEPTH(BUF_DEPTH), .PW(PW)) u_chk (
   .clk(clk), .rst_n(rst_n), .gt_req(gt_req), .be_eop(be_eop), .cr_in(cr_in),
   .sel_valid(sel_valid), .sel_gt(sel_gt), .sel_src(sel_src),
   .gt_pop(gt_pop), .be_pop(be_pop)
);

// File: tb/flit_sched_bench.sv
`timescale 1ns/1ps
module flit_sched_bench;
   localparam int N  = 6;
   localparam int D  = 24;
   localparam int PW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0]    gt_req = '0, be_req = '0, be_eop = '0, cr_in = '0;
   logic [N*PW-1:0] gt_dst = '0, be_dst = '0;
   logic [N-1:0]    sel_valid, sel_gt, gt_pop, be_pop, cr_out;
   logic [N*PW-1:0] sel_src;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   flit_sched #(.NPORT(N), .BUF_DEPTH(D)) u_flit_sched (
      .clk(clk), .rst_n(rst_n), .gt_req(gt_req), .gt_dst(gt_dst),
      .be_req(be_req), .be_dst(be_dst), .be_eop(be_eop), .cr_in(cr_in),
      .sel_valid(sel_valid), .sel_gt(sel_gt), .sel_src(sel_src),
      .gt_pop(gt_pop), .be_pop(be_pop), .cr_out(cr_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int src_of(input int o);
      return int'(sel_src[o*PW +: PW]);
   endfunction

   task automatic clr();
      gt_req = '0; be_req = '0; be_eop = '0; cr_in = '0;
   endtask
   task automatic put_gt(input int i, input int d);
      gt_req[i] = 1'b1; gt_dst[i*PW +: PW] = PW'(d);
   endtask
   task automatic put_be(input int i, input int d, input bit e);
      be_req[i] = 1'b1; be_dst[i*PW +: PW] = PW'(d); be_eop[i] = e;
   endtask
   task automatic step();
      @(posedge clk); #1;
   endtask
   task automatic do_reset();
      clr(); rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset(); step();
      chk("R10 sel_valid", int'(sel_valid), 0);
      chk("R10 gt_pop", int'(gt_pop), 0);
      chk("R10 be_pop", int'(be_pop), 0);
      chk("R10 cr_out", int'(cr_out), 0);
   endtask

   task automatic t_gt();
      do_reset();
      put_gt(1, 3); put_gt(4, 0); step(); clr();
      chk("R1 out3 valid", int'(sel_valid[3]), 1);
      chk("R1 out3 gt", int'(sel_gt[3]), 1);
      chk("R1 out3 src", src_of(3), 1);
      chk("R1 out0 src", src_of(0), 4);
      chk("R1 gt_pop", int'(gt_pop), 6'b010010);
      chk("R9 no credit for GT", int'(cr_out), 0);
   endtask

   task automatic t_class_mix();
      do_reset();
      put_gt(2, 1); put_be(0, 1, 1); put_be(3, 2, 1);
      put_gt(5, 4); put_be(5, 0, 1);
      step(); clr();
      chk("R2 out1 is gt", int'(sel_gt[1]), 1);
      chk("R2 out1 src", src_of(1), 2);
      chk("R2 out2 be src", src_of(2), 3);
      chk("R3 out0 idle", int'(sel_valid[0]), 0);
      chk("R3 be_pop", int'(be_pop), 6'b001000);
   endtask

   task automatic t_rr();
      do_reset();
      put_be(1, 2, 1); put_be(3, 2, 1);
      step();
      chk("R4 first winner", src_of(2), 1);
      chk("R9 cr_out", int'(cr_out), 6'b000010);
      step();
      chk("R4 second winner", src_of(2), 3);
      step(); clr();
      chk("R4 wrap winner", src_of(2), 1);
   endtask

   task automatic t_lock();
      do_reset();
      put_be(0, 2, 0); put_be(1, 2, 0); step();
      chk("R5 head winner", src_of(2), 0);
      step();
      chk("R5 lock held", src_of(2), 0);
      be_req[0] = 1'b0; step();
      chk("R5 paused owner idle", int'(sel_valid[2]), 0);
      put_be(0, 2, 1); step();
      chk("R5 tail from owner", src_of(2), 0);
      be_req[0] = 1'b0; put_be(1, 2, 1); step(); clr();
      chk("R5 released", src_of(2), 1);
      chk("R5 released valid", int'(sel_valid[2]), 1);
   endtask

   task automatic t_gt_in_lock();
      do_reset();
      put_be(0, 2, 0); step();
      chk("R6 lock start", src_of(2), 0);
      put_gt(3, 2); put_be(1, 2, 1); step();
      chk("R6 gt cuts in", int'(sel_gt[2]), 1);
      chk("R6 gt src", src_of(2), 3);
      chk("R6 no be pop", int'(be_pop), 0);
      clr(); put_be(0, 2, 1); put_be(1, 2, 1); step(); clr();
      chk("R6 lock kept", src_of(2), 0);
      chk("R6 be class", int'(sel_gt[2]), 0);
   endtask

   task automatic t_credit();
      int got;
      do_reset();
      got = 0;
      put_be(0, 5, 1);
      for (int k = 0; k < D; k++) begin
         step();
         got += int'(sel_valid[5]);
      end
      chk("R7 grants up to depth", got, D);
      step();
      chk("R7 stall at zero", int'(sel_valid[5]), 0);
      put_gt(1, 5); step(); gt_req = '0;
      chk("R8 gt without credit", int'(sel_gt[5]), 1);
      chk("R8 gt src", src_of(5), 1);
      cr_in[5] = 1'b1; step(); cr_in = '0;
      chk("R7 credit not yet usable", int'(sel_valid[5]), 0);
      step();
      chk("R7 credit used", int'(sel_valid[5]), 1);
      chk("R7 credit src", src_of(5), 0);
      step(); clr();
      chk("R7 empty again", int'(sel_valid[5]), 0);
   endtask

   initial begin
      t_reset();
      t_gt();
      t_class_mix();
      t_rr();
      t_lock();
      t_gt_in_lock();
      t_credit();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule